// File: doc/BRIEF.md
# Exception Entry Stack Frame Pusher

This sequencer writes the register state that must survive an exception onto the stack when the exception is taken. It takes a snapshot of the stack pointer and the registers when it is started. It then stores the eight-word caller-saved frame through a word-wide memory write port. On request it also stores a second frame that holds an integrity signature and the callee-saved registers. Each store gets its own response, which is either success or one of three fault kinds. The sequencer waits for that response before it issues the next store.

The first failing store ends the sequence, and no later word is written. The new stack pointer is still reported as though every store had succeeded. The fault kind, the faulting address (for security faults) and a derived-fault flag are reported when the sequence finishes. A separate input marks that a derived exception is already in progress. In that case the fault is still reported, but the request to pend a new exception is held back.

Top module: `framepush_top`

## Requirements
- R1: When `alignEn` is 1 and bit 2 of `spIn` is 1, the frame is placed 4 bytes lower. Bit 9 of the stored status word is then set. Otherwise no adjustment is made and status bit 9 is stored as supplied.
- R2: The caller frame base is the (adjusted) pointer minus 0x20. Words are written at ascending addresses base+0..base+28 in this order: `basicRegs[0]` to `basicRegs[7]`. The slots are r0, r1, r2, r3, r12, lr, pc and status.
- R3: When `withCallee` is 1 and the caller frame completes, a second frame follows at caller base minus 0x28. The sequence is: the signature 0xFEFA125B at offset 0, then `calleeRegs[0]` to `calleeRegs[7]` at offsets 0x08 to 0x24. Offset 0x04 is never written.
- R4: At most one store is outstanding at a time. `memReq` stays high with a stable address and data until `memAck` is seen.
- R5: A response with a nonzero `memFault` ends the sequence at once. No further store is requested.
- R6: `spOut` equals the lowest frame base that was planned. This is the caller base, or the callee base when `withCallee` is 1. The value holds whether or not a store failed.
- R7: `faultClass` reports the failing response: 0 none, 1 protection, 2 security, 3 bus. `faultAddr` holds the failing address for a security fault and 0 otherwise.
- R8: `pendFault` pulses with `done` only when a store failed and `ignoreFaults` was 0 at start. `faultClass` and `derivedFault` are reported in either case.
- R9: `done` is a single-cycle pulse with `busy` high. `busy` is high from the cycle after `start` until `done`, and `start` has no effect while `busy` is high.
- R10: After reset `busy`, `done`, `memReq` and `pendFault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a push, sampled when idle |
| spIn | input | 32 | Stack pointer before the push |
| alignEn | input | 1 | Enable 8-byte frame alignment |
| withCallee | input | 1 | Also store the callee-saved frame |
| ignoreFaults | input | 1 | Suppress pending of a stacking fault |
| basicRegs | input | 8x32 | r0, r1, r2, r3, r12, lr, pc, status |
| calleeRegs | input | 8x32 | r4 to r11 |
| memReq | output | 1 | Store request |
| memAddr | output | 32 | Store address |
| memData | output | 32 | Store data |
| memAck | input | 1 | Response valid for the current store |
| memFault | input | 2 | Response kind: 0 ok, 1 protection, 2 security, 3 bus |
| busy | output | 1 | Push in progress |
| done | output | 1 | One-cycle completion pulse |
| spOut | output | 32 | New stack pointer |
| derivedFault | output | 1 | A store failed during the last push |
| pendFault | output | 1 | Request to pend the stacking fault (with done) |
| faultClass | output | 2 | Kind of the failing response |
| faultAddr | output | 32 | Failing address for a security fault |

## Verification
The hardest cases to reach are a fault on one chosen word deep in the sequence, such as the last callee word, or a fault on the very first store. These must come with uneven response delays and with a new `start` that arrives in the middle of a push. The bench memory model keeps a count of responses and turns exactly the chosen one into a fault of a chosen kind. Each store is acknowledged after a random delay. The stimulus mixes directed cases at the frame edges with a seeded random sweep of pointers, enables and fault positions.

// File: rtl/framepush_pkg.sv
package framepush_pkg;

  localparam int BASIC_WORDS = 8;
  localparam int CALLEE_REGS = 8;

  typedef enum logic [1:0] {
    RESP_OK   = 2'd0,
    RESP_PROT = 2'd1,
    RESP_SEC  = 2'd2,
    RESP_BUS  = 2'd3
  } memResp_e;

  typedef struct packed {
    logic load;
    logic advance;
    logic capture;
  } pushStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_FIN   = 2'd2
  } pushState_e;

endpackage

// File: rtl/framepush_ctrl.sv
module framepush_ctrl
  import framepush_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memAck,
  input  memResp_e    memResp,
  input  logic        lastWord,
  output pushStrobe_t strobe,
  output logic        memReq,
  output logic        busy,
  output logic        done
);

  pushState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateD      = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (memAck) begin
          if (memResp != RESP_OK) begin
            strobe.capture = 1'b1;
            stateD         = ST_FIN;
          end else if (lastWord) begin
            stateD = ST_FIN;
          end else begin
            strobe.advance = 1'b1;
          end
        end
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign memReq = (stateQ == ST_WRITE);
  assign busy   = (stateQ != ST_IDLE);
  assign done   = (stateQ == ST_FIN);

  // R4: a request is held until it is answered
  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq);

  // R5: nothing is requested after a faulting response
  assert_stop_on_fault_R5: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck && (memResp != RESP_OK) |=> !memReq);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/framepush_datapath.sv
module framepush_datapath
  import framepush_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                REALIGN_BIT = 9,
  parameter logic [DATA_W-1:0] SIG_WORD    = 32'hFEFA125B
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  pushStrobe_t                         strobe,
  input  logic [DATA_W-1:0]                   spIn,
  input  logic                                alignEn,
  input  logic                                withCallee,
  input  logic                                ignoreFaults,
  input  logic [BASIC_WORDS-1:0][DATA_W-1:0]  basicRegs,
  input  logic [CALLEE_REGS-1:0][DATA_W-1:0]  calleeRegs,
  input  memResp_e                            memResp,
  output logic [DATA_W-1:0]                   memAddr,
  output logic [DATA_W-1:0]                   memData,
  output logic                                lastWord,
  output logic [DATA_W-1:0]                   spOut,
  output logic                                derivedFault,
  output logic                                ignoreLatched,
  output memResp_e                            faultClass,
  output logic [DATA_W-1:0]                   faultAddr
);

  localparam int WORD_BYTES   = DATA_W / 8;
  localparam int ALIGN_BIT    = $clog2(WORD_BYTES);
  localparam int TOTAL_WORDS  = BASIC_WORDS + 1 + CALLEE_REGS;
  localparam int IDX_W        = $clog2(TOTAL_WORDS);
  localparam logic [DATA_W-1:0] WORD_BYTES_W   = DATA_W'(WORD_BYTES);
  localparam logic [DATA_W-1:0] BASIC_BYTES_W  = DATA_W'(BASIC_WORDS * WORD_BYTES);
  localparam logic [DATA_W-1:0] CALLEE_BYTES_W = DATA_W'((CALLEE_REGS + 2) * WORD_BYTES);
  localparam logic [IDX_W-1:0]  LAST_BASIC     = IDX_W'(BASIC_WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_ALL       = IDX_W'(TOTAL_WORDS - 1);
  localparam logic [IDX_W-1:0]  FIRST_CALLEE   = IDX_W'(BASIC_WORDS);

  logic [TOTAL_WORDS-1:0][DATA_W-1:0] frameQ;
  logic [DATA_W-1:0] basicBaseQ, calleeBaseQ, spOutQ;
  logic [IDX_W-1:0]  idxQ;
  logic              withCalleeQ;

  // frame geometry from the incoming pointer
  logic              alignAdj;
  logic [DATA_W-1:0] alignedSp, basicBaseD, calleeBaseD;
  always_comb begin
    alignAdj    = alignEn && spIn[ALIGN_BIT];
    alignedSp   = spIn - (alignAdj ? WORD_BYTES_W : '0);
    basicBaseD  = alignedSp - BASIC_BYTES_W;
    calleeBaseD = basicBaseD - CALLEE_BYTES_W;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ      <= '0;
      basicBaseQ  <= '0;
      calleeBaseQ <= '0;
      spOutQ      <= '0;
      withCalleeQ <= 1'b0;
    end else if (strobe.load) begin
      for (int i = 0; i < BASIC_WORDS; i++) frameQ[i] <= basicRegs[i];
      frameQ[BASIC_WORDS-1][REALIGN_BIT] <= basicRegs[BASIC_WORDS-1][REALIGN_BIT] | alignAdj;
      frameQ[BASIC_WORDS] <= SIG_WORD;
      for (int j = 0; j < CALLEE_REGS; j++) frameQ[BASIC_WORDS+1+j] <= calleeRegs[j];
      basicBaseQ  <= basicBaseD;
      calleeBaseQ <= calleeBaseD;
      spOutQ      <= withCallee ? calleeBaseD : basicBaseD;
      withCalleeQ <= withCallee;
    end
  end

  // word index walks through the caller frame, then the callee frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               idxQ <= '0;
    else if (strobe.load)    idxQ <= '0;
    else if (strobe.advance) idxQ <= idxQ + 1'b1;
  end

  // address of the current word; callee slot k>0 sits at (k+1) words
  logic [DATA_W-1:0] slotOffset;
  logic [IDX_W-1:0]  calleeSlot;
  always_comb begin
    calleeSlot = idxQ - FIRST_CALLEE;
    if (idxQ < FIRST_CALLEE) begin
      slotOffset = DATA_W'(idxQ) << ALIGN_BIT;
      memAddr    = basicBaseQ + slotOffset;
    end else begin
      slotOffset = (calleeSlot == '0) ? '0 : (DATA_W'(calleeSlot) + 1'b1) << ALIGN_BIT;
      memAddr    = calleeBaseQ + slotOffset;
    end
    memData  = frameQ[idxQ];
    lastWord = (idxQ == (withCalleeQ ? LAST_ALL : LAST_BASIC));
  end

  // fault recording
  memResp_e          faultClassQ;
  logic [DATA_W-1:0] faultAddrQ;
  logic              failedQ, ignoreQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultClassQ <= RESP_OK;
      faultAddrQ  <= '0;
      failedQ     <= 1'b0;
      ignoreQ     <= 1'b0;
    end else if (strobe.load) begin
      faultClassQ <= RESP_OK;
      faultAddrQ  <= '0;
      failedQ     <= 1'b0;
      ignoreQ     <= ignoreFaults;
    end else if (strobe.capture) begin
      faultClassQ <= memResp;
      faultAddrQ  <= (memResp == RESP_SEC) ? memAddr : '0;
      failedQ     <= 1'b1;
    end
  end

  assign spOut         = spOutQ;
  assign derivedFault  = failedQ;
  assign ignoreLatched = ignoreQ;
  assign faultClass    = faultClassQ;
  assign faultAddr     = faultAddrQ;

  // R7: a recorded fault always carries a fault kind
  assert_class_when_failed_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> derivedFault && (faultClass != RESP_OK));

endmodule

// File: rtl/framepush_top.sv
module framepush_top
  import framepush_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                REALIGN_BIT = 9,
  parameter logic [DATA_W-1:0] SIG_WORD    = 32'hFEFA125B
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic [DATA_W-1:0]                  spIn,
  input  logic                               alignEn,
  input  logic                               withCallee,
  input  logic                               ignoreFaults,
  input  logic [BASIC_WORDS-1:0][DATA_W-1:0] basicRegs,
  input  logic [CALLEE_REGS-1:0][DATA_W-1:0] calleeRegs,
  output logic                               memReq,
  output logic [DATA_W-1:0]                  memAddr,
  output logic [DATA_W-1:0]                  memData,
  input  logic                               memAck,
  input  logic [1:0]                         memFault,
  output logic                               busy,
  output logic                               done,
  output logic [DATA_W-1:0]                  spOut,
  output logic                               derivedFault,
  output logic                               pendFault,
  output logic [1:0]                         faultClass,
  output logic [DATA_W-1:0]                  faultAddr
);

  pushStrobe_t strobe;
  memResp_e    memResp;
  memResp_e    faultClassE;
  logic        lastWord;
  logic        ignoreLatched;

  assign memResp = memResp_e'(memFault);

  framepush_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .memAck   (memAck),
    .memResp  (memResp),
    .lastWord (lastWord),
    .strobe   (strobe),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done)
  );

  framepush_datapath #(
    .DATA_W      (DATA_W),
    .REALIGN_BIT (REALIGN_BIT),
    .SIG_WORD    (SIG_WORD)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .spIn          (spIn),
    .alignEn       (alignEn),
    .withCallee    (withCallee),
    .ignoreFaults  (ignoreFaults),
    .basicRegs     (basicRegs),
    .calleeRegs    (calleeRegs),
    .memResp       (memResp),
    .memAddr       (memAddr),
    .memData       (memData),
    .lastWord      (lastWord),
    .spOut         (spOut),
    .derivedFault  (derivedFault),
    .ignoreLatched (ignoreLatched),
    .faultClass    (faultClassE),
    .faultAddr     (faultAddr)
  );

  assign faultClass = faultClassE;
  assign pendFault  = done && derivedFault && !ignoreLatched;

  // R4: address and data do not move while a store waits
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memData));

  // R8: a pend request always comes with a fault kind
  assert_pend_has_class_R8: assert property (@(posedge clk) disable iff (!rstN)
    pendFault |-> done && (faultClass != 2'd0));

  // R9: completion happens while busy
  assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

// File: tb/framepush_top_bench.sv
module framepush_top_bench;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [31:0]       spIn = '0;
  logic              alignEn = 1'b0;
  logic              withCallee = 1'b0;
  logic              ignoreFaults = 1'b0;
  logic [7:0][31:0]  basicRegs = '0;
  logic [7:0][31:0]  calleeRegs = '0;
  logic              memReq;
  logic [31:0]       memAddr, memData;
  logic              memAck = 1'b0;
  logic [1:0]        memFault = 2'd0;
  logic              busy, done, derivedFault, pendFault;
  logic [31:0]       spOut, faultAddr;
  logic [1:0]        faultClass;

  framepush_top u_framepush_top (
    .clk(clk), .rstN(rstN), .start(start), .spIn(spIn), .alignEn(alignEn),
    .withCallee(withCallee), .ignoreFaults(ignoreFaults),
    .basicRegs(basicRegs), .calleeRegs(calleeRegs),
    .memReq(memReq), .memAddr(memAddr), .memData(memData),
    .memAck(memAck), .memFault(memFault),
    .busy(busy), .done(done), .spOut(spOut), .derivedFault(derivedFault),
    .pendFault(pendFault), .faultClass(faultClass), .faultAddr(faultAddr)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory model state
  int          ackCount = 0;
  int          wrCount = 0;
  int          waitLeft = 0;
  int          maxWait = 3;
  int          failAt = 99;
  logic [1:0]  failCode = 2'd0;
  logic [31:0] logAddr [0:31];
  logic [31:0] logData [0:31];

  always @(negedge clk) begin
    if (!rstN) begin
      memAck = 1'b0; memFault = 2'd0;
    end else if (memAck) begin
      memAck = 1'b0; memFault = 2'd0;
    end else if (memReq) begin
      if (waitLeft > 0) waitLeft--;
      else begin
        memAck = 1'b1;
        if (ackCount == failAt) memFault = failCode;
        else begin
          memFault = 2'd0;
          if (wrCount < 32) begin
            logAddr[wrCount] = memAddr;
            logData[wrCount] = memData;
          end
          wrCount++;
        end
        ackCount++;
        waitLeft = $urandom_range(0, maxWait);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected model from the requirements
  function automatic bit adjOf(input logic [31:0] sp, input logic al);
    return al && sp[2];
  endfunction
  function automatic logic [31:0] baseOf(input logic [31:0] sp, input logic al);
    return sp - (adjOf(sp, al) ? 32'd4 : 32'd0) - 32'h20;
  endfunction
  function automatic logic [31:0] expAddr(input int i, input logic [31:0] sp, input logic al);
    logic [31:0] b;
    b = baseOf(sp, al);
    if (i < 8) return b + 32'(4 * i);
    if (i == 8) return b - 32'h28;
    return b - 32'h28 + 32'h8 + 32'(4 * (i - 9));
  endfunction
  function automatic logic [31:0] expData(input int i, input logic [31:0] sp, input logic al);
    logic [31:0] s;
    if (i < 7) return basicRegs[i];
    if (i == 7) begin
      s = basicRegs[7];
      if (adjOf(sp, al)) s[9] = 1'b1;
      return s;
    end
    if (i == 8) return 32'hFEFA125B;
    return calleeRegs[i-9];
  endfunction

  task automatic runPush(input logic [31:0] sp, input logic al, input logic wc,
                         input logic ign, input int fAt, input logic [1:0] fCode,
                         input bit poke);
    int total, expWr, expAcks, it;
    bit failing;
    logic [31:0] fa;
    for (int k = 0; k < 8; k++) begin
      basicRegs[k]  = $urandom;
      calleeRegs[k] = $urandom;
    end
    total    = wc ? 17 : 8;
    failing  = (fAt < total);
    expWr    = failing ? fAt : total;
    expAcks  = failing ? fAt + 1 : total;
    @(negedge clk);
    ackCount = 0; wrCount = 0; waitLeft = $urandom_range(0, maxWait);
    failAt = fAt; failCode = fCode;
    spIn = sp; alignEn = al; withCallee = wc; ignoreFaults = ign; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R9", "busy after start", 32'(busy), 32'd1);
    it = 0;
    while (done !== 1'b1 && it < 400) begin
      @(negedge clk);
      it++;
      if (poke && it == 2) begin start = 1'b1; spIn = ~sp; withCallee = ~wc; end
      if (poke && it == 3) begin start = 1'b0; spIn = sp; withCallee = wc; end
    end
    start = 1'b0;
    check(done === 1'b1, "R9", "done seen", 32'(done), 32'd1);
    check(busy === 1'b1, "R9", "busy with done", 32'(busy), 32'd1);
    check(wrCount == expWr, "R5", "stores completed", 32'(wrCount), 32'(expWr));
    check(ackCount == expAcks, "R4", "responses consumed", 32'(ackCount), 32'(expAcks));
    for (int i = 0; i < expWr && i < 32; i++) begin
      check(logAddr[i] === expAddr(i, sp, al), (i < 8) ? "R2" : "R3", "address",
            logAddr[i], expAddr(i, sp, al));
      check(logData[i] === expData(i, sp, al), (i == 7) ? "R1" : ((i < 8) ? "R2" : "R3"),
            "data", logData[i], expData(i, sp, al));
    end
    check(spOut === (wc ? baseOf(sp, al) - 32'h28 : baseOf(sp, al)), "R6", "spOut",
          spOut, wc ? baseOf(sp, al) - 32'h28 : baseOf(sp, al));
    check(derivedFault === failing, "R9", "derivedFault", 32'(derivedFault), 32'(failing));
    check(faultClass === (failing ? fCode : 2'd0), "R7", "faultClass",
          32'(faultClass), 32'(failing ? fCode : 2'd0));
    fa = (failing && fCode == 2'd2) ? expAddr(fAt, sp, al) : 32'd0;
    check(faultAddr === fa, "R7", "faultAddr", faultAddr, fa);
    check(pendFault === (failing && !ign), "R8", "pendFault",
          32'(pendFault), 32'(failing && !ign));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9", "done pulse ended",
          {30'd0, done, busy}, 32'd0);
    check(memReq === 1'b0, "R5", "no request after end", 32'(memReq), 32'd0);
    failAt = 99;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && memReq === 1'b0 && pendFault === 1'b0,
          "R10", "reset outputs", {28'd0, busy, done, memReq, pendFault}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && memReq === 1'b0, "R10", "idle after reset",
          {30'd0, busy, memReq}, 32'd0);

    // directed corners
    runPush(32'h2000_1004, 1'b1, 1'b0, 1'b0, 99, 2'd0, 1'b0); // R1 adjust applied
    runPush(32'h2000_1004, 1'b0, 1'b0, 1'b0, 99, 2'd0, 1'b0); // R1 alignment disabled
    runPush(32'h2000_1000, 1'b1, 1'b1, 1'b0, 99, 2'd0, 1'b1); // R3 full, R9 start while busy
    runPush(32'h2000_2000, 1'b1, 1'b1, 1'b0, 0,  2'd1, 1'b0); // R5 first store faults
    runPush(32'h2000_200C, 1'b1, 1'b1, 1'b1, 16, 2'd2, 1'b0); // R7 last callee word, ignored
    runPush(32'h2000_3000, 1'b0, 1'b1, 1'b0, 8,  2'd3, 1'b1); // R5 signature store bus error
    runPush(32'h2000_3008, 1'b1, 1'b0, 1'b0, 7,  2'd2, 1'b0); // R7 status word security fault
    maxWait = 0;
    runPush(32'h1FFF_FFFC, 1'b1, 1'b1, 1'b0, 99, 2'd0, 1'b0); // R4 back-to-back responses
    maxWait = 3;

    // seeded random sweep
    for (int n = 0; n < 60; n++) begin
      logic [31:0] sp;
      int fa;
      sp = {$urandom, 2'b00} ;
      fa = ($urandom_range(0, 2) == 0) ? 99 : $urandom_range(0, 16);
      runPush(sp, 1'($urandom), 1'($urandom), 1'($urandom), fa,
              2'($urandom_range(1, 3)), ($urandom_range(0, 3) == 0) && fa >= 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule